// File: doc/BRIEF.md
# Graphics Coprocessor Host Register Window

This block is the host-facing register file of a 16-bit graphics coprocessor. A byte-wide host bus with a 10-bit address reaches a 768-byte window. In that window sit sixteen 16-bit working registers, a 16-bit flag word, a set of 8-bit bank, configuration, screen and mode registers, a cache base pointer and a 512-byte cache RAM. The block drives every stored value towards the execution core as a plain output. The mode fields arrive already decoded.

The host loads the working registers while the core is idle. It then starts the core by writing the upper byte of the last working register, which is the program counter. The core runs until it pulses `core_stop`. The core raises interrupts with `core_irq`. The host acknowledges an interrupt by reading the upper byte of the flag word, and that read clears the pending bit. Host reads are registered, so read data appears one cycle after the strobe.

Top module: `gfx_host_regs`

## Requirements
- R1: Working register n (n = 0..15) sits at offset 2n (bits 7:0) and 2n+1 (bits 15:8). While the core is idle, each byte write changes only its own half, and reads return the stored byte. All sixteen registers appear on `gp_regs_o`, with register n at bits 16n+15:16n.
- R2: A host write to offset 0x01F while idle sets the run flag (`run_o`, flag bit 5) on the next edge. `core_stop` clears it. When a start write and `core_stop` arrive in the same cycle, the start wins. A write to 0x01E alone does not start the core.
- R3: While the run flag is set, host writes to offsets 0x000..0x01F change nothing, and the core is not restarted. Reads of working registers and of the flag word still work.
- R4: The flag word sits at 0x030 (bits 7:0) and 0x031 (bits 15:8). Host writes change only bits 1,2,3,4,6,8,9,10,11,12 (mask 0x1F5E). Bits 0, 7, 13 and 14 always read 0. Host writes never change bit 5 (run) or bit 15 (interrupt).
- R5: A `core_irq` pulse sets flag bit 15. A host read of 0x031 returns the value before the clear, then clears bit 15. If `core_irq` arrives in the same cycle as that read, the bit stays set.
- R6: `irq_req_o` is high exactly when flag bit 15 is set and bit 7 of the configuration register is 0.
- R7: The 8-bit registers read back what was written. They sit at these offsets: backup-RAM enable 0x033, program bank 0x034, ROM bank 0x036, configuration 0x037, screen base 0x038, clock select 0x039, screen mode 0x03A, RAM bank 0x03C. Offset 0x03B returns the VERSION parameter (default 0x04), and writes to it are ignored.
- R8: The cache base register sits at 0x03E/0x03F. Bits 3:0 always read 0 at the port `cache_base_o` and over the bus.
- R9: Offsets 0x100..0x2FF read and write a 512-byte cache RAM, with byte k at offset 0x100+k.
- R10: Offsets 0x020..0x02F, 0x032, 0x035, 0x03D and 0x040..0x0FF read 0x00, and writes to them change no readable state.
- R11: `host_rdata` shows the addressed byte from the first edge after the `host_rd` cycle and holds it until the next read.
- R12: Decoded outputs: `mult_fast_o` = configuration bit 5; `clk_fast_o` = clock select bit 0; `color_depth_o` = screen mode bits 1:0; `height_sel_o` = {screen mode bit 5, bit 2}; `ram_owner_o` = screen mode bit 3; `rom_owner_o` = screen mode bit 4; `bram_en_o` = backup-RAM enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 10 | Byte offset in the window |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_rdata | output | 8 | Registered read byte |
| core_stop | input | 1 | Core stop pulse, clears the run flag |
| core_irq | input | 1 | Core interrupt pulse, sets flag bit 15 |
| run_o | output | 1 | Run flag |
| irq_req_o | output | 1 | Unmasked interrupt request |
| status_o | output | 16 | Flag word |
| gp_regs_o | output | 256 | Working registers 0..15 |
| prog_bank_o | output | 8 | Program bank |
| rom_bank_o | output | 8 | ROM bank |
| ram_bank_o | output | 8 | RAM bank |
| bram_en_o | output | 1 | Backup-RAM enable |
| scr_base_o | output | 8 | Screen base |
| cache_base_o | output | 16 | Cache base, bits 3:0 zero |
| mult_fast_o | output | 1 | Fast multiplier select |
| clk_fast_o | output | 1 | Double clock select |
| color_depth_o | output | 2 | Colour depth field |
| height_sel_o | output | 2 | Screen height field |
| ram_owner_o | output | 1 | Core owns RAM |
| rom_owner_o | output | 1 | Core owns ROM |

## Verification
A wrong decode shows up at `host_rdata` one edge after the read strobe: the wrong byte, or a non-zero value from an unused hole. A wrong run or interrupt state is visible at once on `run_o`, `irq_req_o` and `status_o`, on the edge after the start write, the stop pulse or the acknowledging read. A leak through the run-time write lock stays hidden inside a working register until the host reads it back or the core sees it on `gp_regs_o`. For that reason the bench reads every locked register after the write attempt.

// File: rtl/gfxw_pkg.sv
package gfxw_pkg;
    localparam int GP_COUNT = 16;
    localparam int GP_W     = 16;
    localparam int GP_IW    = $clog2(GP_COUNT);

    localparam int ST_RUN = 5;
    localparam int ST_IRQ = 15;
    localparam logic [15:0] ST_HOST_MASK = 16'h1F5E;

    typedef enum logic [2:0] {
        RG_NONE, RG_GP, RG_STATUS, RG_R8, RG_CBR, RG_CACHE
    } region_e;

    typedef enum logic [3:0] {
        B8_BRAM, B8_PBANK, B8_RBANK, B8_CFG, B8_SBASE,
        B8_CLK, B8_SMODE, B8_VER, B8_RAMB, B8_NONE
    } byte8_e;

    typedef struct packed {
        region_e          region;
        logic [GP_IW-1:0] gp_idx;
        logic             hi;
        byte8_e           b8;
    } dec_t;

    typedef struct packed {
        logic [GP_COUNT-1:0][GP_W-1:0] gp;
        logic [7:0]  bram;
        logic [7:0]  pbank;
        logic [7:0]  rbank;
        logic [7:0]  cfg;
        logic [7:0]  sbase;
        logic [7:0]  clks;
        logic [7:0]  smode;
        logic [7:0]  ramb;
        logic [11:0] cbr_hi;
        logic [7:0]  rdata;
        logic        rd_cache;
    } regs_t;
endpackage

// File: rtl/gfxw_decode.sv
module gfxw_decode
    import gfxw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int CACHE_BASE  = 'h100,
    parameter int CACHE_BYTES = 512,
    localparam int CACHE_AW   = $clog2(CACHE_BYTES)
) (
    input  logic [ADDR_W-1:0]   addr,
    output dec_t                dec,
    output logic [CACHE_AW-1:0] cache_addr
);
    localparam logic [ADDR_W-1:0] GP_END = ADDR_W'(GP_COUNT * 2);
    localparam logic [ADDR_W-1:0] CB_LO  = ADDR_W'(CACHE_BASE);
    localparam logic [ADDR_W-1:0] CB_HI  = ADDR_W'(CACHE_BASE + CACHE_BYTES - 1);

    always_comb begin
        dec.region = RG_NONE;
        dec.b8     = B8_NONE;
        dec.gp_idx = addr[GP_IW:1];
        dec.hi     = addr[0];
        cache_addr = CACHE_AW'(addr - CB_LO);
        if (addr < GP_END) begin
            dec.region = RG_GP;
        end else if (addr >= CB_LO && addr <= CB_HI) begin
            dec.region = RG_CACHE;
        end else begin
            case (addr)
                ADDR_W'('h030), ADDR_W'('h031): dec.region = RG_STATUS;
                ADDR_W'('h03E), ADDR_W'('h03F): dec.region = RG_CBR;
                ADDR_W'('h033): begin dec.region = RG_R8; dec.b8 = B8_BRAM;  end
                ADDR_W'('h034): begin dec.region = RG_R8; dec.b8 = B8_PBANK; end
                ADDR_W'('h036): begin dec.region = RG_R8; dec.b8 = B8_RBANK; end
                ADDR_W'('h037): begin dec.region = RG_R8; dec.b8 = B8_CFG;   end
                ADDR_W'('h038): begin dec.region = RG_R8; dec.b8 = B8_SBASE; end
                ADDR_W'('h039): begin dec.region = RG_R8; dec.b8 = B8_CLK;   end
                ADDR_W'('h03A): begin dec.region = RG_R8; dec.b8 = B8_SMODE; end
                ADDR_W'('h03B): begin dec.region = RG_R8; dec.b8 = B8_VER;   end
                ADDR_W'('h03C): begin dec.region = RG_R8; dec.b8 = B8_RAMB;  end
                default: dec.region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gfxw_status.sv
module gfxw_status
    import gfxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [7:0]  wdata,
    input  logic        start,
    input  logic        stop,
    input  logic        raise,
    input  logic        ack,
    output logic [15:0] status_q
);
    logic [15:0] status_d;

    always_comb begin
        status_d = status_q;
        if (wr_lo)
            status_d[7:0] = (status_q[7:0] & ~ST_HOST_MASK[7:0]) | (wdata & ST_HOST_MASK[7:0]);
        if (wr_hi)
            status_d[15:8] = (status_q[15:8] & ~ST_HOST_MASK[15:8]) | (wdata & ST_HOST_MASK[15:8]);
        if (stop)  status_d[ST_RUN] = 1'b0;
        if (start) status_d[ST_RUN] = 1'b1;
        if (ack)   status_d[ST_IRQ] = 1'b0;
        if (raise) status_d[ST_IRQ] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R5: an acknowledge without a new raise leaves the interrupt bit clear
    p_irq_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !raise) |=> !status_q[ST_IRQ]);
    // R2: a stop with no competing start drops the run flag
    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !status_q[ST_RUN]);
    // R4: host writes never move the run or interrupt bits
    p_host_no_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_lo || wr_hi) && !start && !stop && !raise && !ack)
        |=> ($stable(status_q[ST_RUN]) && $stable(status_q[ST_IRQ])));
endmodule

// File: rtl/gfxw_cache.sv
module gfxw_cache #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/gfx_host_regs.sv
module gfx_host_regs
    import gfxw_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter int          CACHE_BASE  = 'h100,
    parameter int          CACHE_BYTES = 512,
    parameter logic [7:0]  VERSION     = 8'h04,
    localparam int         CACHE_AW    = $clog2(CACHE_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [7:0]                host_wdata,
    input  logic                      host_wr,
    input  logic                      host_rd,
    output logic [7:0]                host_rdata,
    input  logic                      core_stop,
    input  logic                      core_irq,
    output logic                      run_o,
    output logic                      irq_req_o,
    output logic [15:0]               status_o,
    output logic [GP_COUNT*GP_W-1:0]  gp_regs_o,
    output logic [7:0]                prog_bank_o,
    output logic [7:0]                rom_bank_o,
    output logic [7:0]                ram_bank_o,
    output logic                      bram_en_o,
    output logic [7:0]                scr_base_o,
    output logic [15:0]               cache_base_o,
    output logic                      mult_fast_o,
    output logic                      clk_fast_o,
    output logic [1:0]                color_depth_o,
    output logic [1:0]                height_sel_o,
    output logic                      ram_owner_o,
    output logic                      rom_owner_o
);
    dec_t                dec;
    logic [CACHE_AW-1:0] cache_addr;
    logic [7:0]          cache_rdata;
    logic [15:0]         status_q;
    regs_t               r_d, r_q;
    logic                wr_gp, start, st_wr_lo, st_wr_hi, st_ack, cache_we, cache_re;
    logic [7:0]          rd_val;

    gfxw_decode #(
        .ADDR_W(ADDR_W), .CACHE_BASE(CACHE_BASE), .CACHE_BYTES(CACHE_BYTES)
    ) u_decode (
        .addr(host_addr), .dec(dec), .cache_addr(cache_addr)
    );

    gfxw_status u_status (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(st_wr_lo), .wr_hi(st_wr_hi), .wdata(host_wdata),
        .start(start), .stop(core_stop), .raise(core_irq), .ack(st_ack),
        .status_q(status_q)
    );

    gfxw_cache #(.DEPTH(CACHE_BYTES)) u_cache (
        .clk(clk), .we(cache_we), .re(cache_re), .addr(cache_addr),
        .wdata(host_wdata), .rdata(cache_rdata)
    );

    always_comb begin
        run_o    = status_q[ST_RUN];
        wr_gp    = host_wr && dec.region == RG_GP && !run_o;
        start    = wr_gp && dec.hi && dec.gp_idx == GP_IW'(GP_COUNT - 1);
        st_wr_lo = host_wr && dec.region == RG_STATUS && !dec.hi;
        st_wr_hi = host_wr && dec.region == RG_STATUS && dec.hi;
        st_ack   = host_rd && dec.region == RG_STATUS && dec.hi;
        cache_we = host_wr && dec.region == RG_CACHE;
        cache_re = host_rd && dec.region == RG_CACHE;

        case (dec.region)
            RG_GP:     rd_val = dec.hi ? r_q.gp[dec.gp_idx][15:8] : r_q.gp[dec.gp_idx][7:0];
            RG_STATUS: rd_val = dec.hi ? status_q[15:8] : status_q[7:0];
            RG_CBR:    rd_val = dec.hi ? r_q.cbr_hi[11:4] : {r_q.cbr_hi[3:0], 4'h0};
            RG_R8: begin
                case (dec.b8)
                    B8_BRAM:  rd_val = r_q.bram;
                    B8_PBANK: rd_val = r_q.pbank;
                    B8_RBANK: rd_val = r_q.rbank;
                    B8_CFG:   rd_val = r_q.cfg;
                    B8_SBASE: rd_val = r_q.sbase;
                    B8_CLK:   rd_val = r_q.clks;
                    B8_SMODE: rd_val = r_q.smode;
                    B8_VER:   rd_val = VERSION;
                    B8_RAMB:  rd_val = r_q.ramb;
                    default:  rd_val = 8'h00;
                endcase
            end
            default:   rd_val = 8'h00;
        endcase

        r_d = r_q;
        if (wr_gp) begin
            if (dec.hi) r_d.gp[dec.gp_idx][15:8] = host_wdata;
            else        r_d.gp[dec.gp_idx][7:0]  = host_wdata;
        end
        if (host_wr && dec.region == RG_R8) begin
            case (dec.b8)
                B8_BRAM:  r_d.bram  = host_wdata;
                B8_PBANK: r_d.pbank = host_wdata;
                B8_RBANK: r_d.rbank = host_wdata;
                B8_CFG:   r_d.cfg   = host_wdata;
                B8_SBASE: r_d.sbase = host_wdata;
                B8_CLK:   r_d.clks  = host_wdata;
                B8_SMODE: r_d.smode = host_wdata;
                B8_RAMB:  r_d.ramb  = host_wdata;
                default:  ;
            endcase
        end
        if (host_wr && dec.region == RG_CBR) begin
            if (dec.hi) r_d.cbr_hi[11:4] = host_wdata;
            else        r_d.cbr_hi[3:0]  = host_wdata[7:4];
        end
        if (host_rd) begin
            r_d.rd_cache = dec.region == RG_CACHE;
            r_d.rdata    = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        host_rdata    = r_q.rd_cache ? cache_rdata : r_q.rdata;
        irq_req_o     = status_q[ST_IRQ] && !r_q.cfg[7];
        status_o      = status_q;
        gp_regs_o     = r_q.gp;
        prog_bank_o   = r_q.pbank;
        rom_bank_o    = r_q.rbank;
        ram_bank_o    = r_q.ramb;
        bram_en_o     = r_q.bram[0];
        scr_base_o    = r_q.sbase;
        cache_base_o  = {r_q.cbr_hi, 4'h0};
        mult_fast_o   = r_q.cfg[5];
        clk_fast_o    = r_q.clks[0];
        color_depth_o = r_q.smode[1:0];
        height_sel_o  = {r_q.smode[5], r_q.smode[2]};
        ram_owner_o   = r_q.smode[3];
        rom_owner_o   = r_q.smode[4];
    end

    // R2: an idle write to the counter's upper byte starts the core
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'('h01F) && !run_o) |=> run_o);
    // R3: the working registers are frozen against host writes while running
    p_gp_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && host_wr && host_addr < ADDR_W'(GP_COUNT * 2)) |=> $stable(gp_regs_o));
    // R10: holes in the map read as zero
    p_hole_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && dec.region == RG_NONE) |=> host_rdata == 8'h00);
    // R8: the low nibble of the cache base reads zero over the bus
    p_cbr_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'('h03E)) |=> host_rdata[3:0] == 4'h0);
    // R11: read data holds between reads
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !$past(host_rd)) |=> $stable(host_rdata));
endmodule

// File: tb/gfx_host_regs_bench.sv
`timescale 1ns/1ps
module gfx_host_regs_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9:0]   host_addr = '0;
    logic [7:0]   host_wdata = '0;
    logic         host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]   host_rdata;
    logic         core_stop = 1'b0, core_irq = 1'b0;
    logic         run_o, irq_req_o, bram_en_o, mult_fast_o, clk_fast_o, ram_owner_o, rom_owner_o;
    logic [15:0]  status_o, cache_base_o;
    logic [255:0] gp_regs_o;
    logic [7:0]   prog_bank_o, rom_bank_o, ram_bank_o, scr_base_o;
    logic [1:0]   color_depth_o, height_sel_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gfx_host_regs u_gfx_host_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .core_stop(core_stop), .core_irq(core_irq), .run_o(run_o), .irq_req_o(irq_req_o),
        .status_o(status_o), .gp_regs_o(gp_regs_o), .prog_bank_o(prog_bank_o),
        .rom_bank_o(rom_bank_o), .ram_bank_o(ram_bank_o), .bram_en_o(bram_en_o),
        .scr_base_o(scr_base_o), .cache_base_o(cache_base_o), .mult_fast_o(mult_fast_o),
        .clk_fast_o(clk_fast_o), .color_depth_o(color_depth_o), .height_sel_o(height_sel_o),
        .ram_owner_o(ram_owner_o), .rom_owner_o(rom_owner_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic pulse_stop();
        @(negedge clk); core_stop = 1'b1;
        @(negedge clk); core_stop = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 reset rdata", host_rdata, 0);
        check("R2 reset run", run_o, 0);
        check("R6 reset irq_req", irq_req_o, 0);
        check("R4 reset status", status_o, 0);
    endtask

    task automatic t_gp();
        logic [7:0] v;
        wr(10'h006, 8'hEF); wr(10'h007, 8'hBE);
        rd(10'h006, v); check("R1 r3 low", v, 8'hEF);
        rd(10'h007, v); check("R1 r3 high", v, 8'hBE);
        check("R1 gp_regs_o r3", gp_regs_o[63:48], 16'hBEEF);
        wr(10'h000, 8'h5A);
        check("R1 r0 low only", gp_regs_o[15:0], 16'h005A);
        rd(10'h001, v); check("R1 r0 high untouched", v, 8'h00);
        wr(10'h00A, 8'h34); wr(10'h00B, 8'h12);
        check("R11 hold after read", host_rdata, 8'h00);
    endtask

    task automatic t_start_stop();
        wr(10'h01E, 8'h00);
        check("R2 low byte no start", run_o, 0);
        wr(10'h01F, 8'h80);
        check("R2 high byte starts", run_o, 1);
        check("R2 status run bit", status_o[5], 1);
        check("R1 counter value", gp_regs_o[255:240], 16'h8000);
        pulse_stop();
        check("R2 stop clears run", run_o, 0);
        @(negedge clk); host_addr = 10'h01F; host_wdata = 8'h81; host_wr = 1'b1; core_stop = 1'b1;
        @(negedge clk); host_wr = 1'b0; core_stop = 1'b0;
        check("R2 start beats stop", run_o, 1);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        wr(10'h00A, 8'h55); wr(10'h00B, 8'h66); wr(10'h01F, 8'h00);
        rd(10'h00A, v); check("R3 r5 low locked", v, 8'h34);
        rd(10'h00B, v); check("R3 r5 high locked", v, 8'h12);
        rd(10'h030, v); check("R3 status readable", v, 8'h20);
        check("R3 counter unchanged", gp_regs_o[255:240], 16'h8100);
        pulse_stop();
        check("R3 stopped", run_o, 0);
    endtask

    task automatic t_status();
        logic [7:0] v;
        wr(10'h030, 8'hFF);
        rd(10'h030, v); check("R4 low mask", v, 8'h5E);
        check("R4 no start via status", run_o, 0);
        wr(10'h031, 8'hFF);
        rd(10'h031, v); check("R4 high mask", v, 8'h1F);
        wr(10'h031, 8'h00); wr(10'h030, 8'h00);
        check("R4 cleared", status_o, 16'h0000);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        @(negedge clk); core_irq = 1'b1;
        @(negedge clk); core_irq = 1'b0;
        check("R5 irq set", status_o[15], 1);
        check("R6 irq_req unmasked", irq_req_o, 1);
        wr(10'h037, 8'h80);
        check("R6 irq_req masked", irq_req_o, 0);
        wr(10'h037, 8'h00);
        rd(10'h030, v); check("R5 low read keeps irq", status_o[15], 1);
        rd(10'h031, v); check("R5 read sees irq", v, 8'h80);
        check("R5 read clears", status_o[15], 0);
        rd(10'h031, v); check("R5 second read", v, 8'h00);
        @(negedge clk); core_irq = 1'b1;
        @(negedge clk); core_irq = 1'b0;
        @(negedge clk); host_addr = 10'h031; host_rd = 1'b1; core_irq = 1'b1;
        @(negedge clk); host_rd = 1'b0; core_irq = 1'b0;
        check("R5 raise beats ack", status_o[15], 1);
        rd(10'h031, v);
        check("R5 final clear", status_o[15], 0);
    endtask

    task automatic t_byte_regs();
        logic [7:0] v;
        wr(10'h033, 8'h01); wr(10'h034, 8'h12); wr(10'h036, 8'h23); wr(10'h037, 8'h20);
        wr(10'h038, 8'h45); wr(10'h039, 8'h01); wr(10'h03A, 8'h3F); wr(10'h03C, 8'h67);
        rd(10'h034, v); check("R7 program bank", v, 8'h12);
        rd(10'h036, v); check("R7 rom bank", v, 8'h23);
        rd(10'h03C, v); check("R7 ram bank", v, 8'h67);
        rd(10'h038, v); check("R7 screen base", v, 8'h45);
        check("R7 ports", {prog_bank_o, rom_bank_o, ram_bank_o, scr_base_o}, 32'h12236745);
        rd(10'h03B, v); check("R7 version", v, 8'h04);
        wr(10'h03B, 8'hAA);
        rd(10'h03B, v); check("R7 version write ignored", v, 8'h04);
        check("R12 bram/mult/clk", {bram_en_o, mult_fast_o, clk_fast_o}, 3'b111);
        check("R12 screen fields", {color_depth_o, height_sel_o, ram_owner_o, rom_owner_o}, 6'b111111);
        wr(10'h03A, 8'h05);
        check("R12 screen fields 2", {color_depth_o, height_sel_o, ram_owner_o, rom_owner_o}, 6'b010100);
    endtask

    task automatic t_cbr();
        logic [7:0] v;
        wr(10'h03E, 8'hAB); wr(10'h03F, 8'hCD);
        rd(10'h03E, v); check("R8 low nibble zero", v, 8'hA0);
        rd(10'h03F, v); check("R8 high byte", v, 8'hCD);
        check("R8 port", cache_base_o, 16'hCDA0);
    endtask

    task automatic t_cache();
        logic [7:0] v;
        wr(10'h100, 8'h11); wr(10'h2FF, 8'h22); wr(10'h1A5, 8'h33);
        rd(10'h100, v); check("R9 first byte", v, 8'h11);
        rd(10'h2FF, v); check("R9 last byte", v, 8'h22);
        rd(10'h1A5, v); check("R9 middle byte", v, 8'h33);
        rd(10'h034, v); check("R9 back to regs", v, 8'h12);
    endtask

    task automatic t_holes();
        logic [7:0] v;
        wr(10'h025, 8'h77); wr(10'h032, 8'h77); wr(10'h035, 8'h77);
        wr(10'h03D, 8'h77); wr(10'h0C0, 8'h77);
        rd(10'h025, v); check("R10 hole 0x025", v, 8'h00);
        rd(10'h032, v); check("R10 hole 0x032", v, 8'h00);
        rd(10'h035, v); check("R10 hole 0x035", v, 8'h00);
        rd(10'h03D, v); check("R10 hole 0x03D", v, 8'h00);
        rd(10'h0C0, v); check("R10 hole 0x0C0", v, 8'h00);
        check("R10 neighbours intact", {prog_bank_o, rom_bank_o, ram_bank_o}, 24'h122367);
        check("R10 status intact", status_o, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gp();
        t_start_stop();
        t_locked();
        t_status();
        t_irq();
        t_byte_regs();
        t_cbr();
        t_cache();
        t_holes();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule